// File: doc/BRIEF.md
# I2C Target Address Acceptance Logic

This block sits behind the byte shifter of an I2C target and decides whether the address phase is acknowledged. The receiver presents the first address byte with one strobe and, for a ten-bit address, the following byte with a second strobe. The block compares these bytes with the configured addresses and returns a one-cycle decision pulse that carries an ACK or NACK verdict. When the verdict is ACK, it sets a sticky match flag and stores the seven-bit address code and the read/write bit of the first byte.

The block accepts two own addresses. The first is ten bits wide and can run in seven-bit or ten-bit mode. The second is seven bits wide and has a three-bit mask code that turns its low bits into don't-care bits. Four bus-wide addresses can also be accepted, each under its own enable: the general call, the SMBus host address, the SMBus device-default address and the alert-response address. Reserved seven-bit addresses are never accepted through the masked second own address.

Top module: `tam_addr_filter`

## Requirements
- R1: After reset, dec_vld, dec_ack, match_flag, match_code and match_dir are all 0.
- R2: With own1_en=1 and own1_ten=0, a first byte whose bits [7:1] equal own1_addr[6:0] gives dec_vld=1 and dec_ack=1 on the cycle after the strobe. With own1_en=0 the same byte gives dec_ack=0.
- R3: With own2_en=1 and mask code k in own2_msk, byte bits [k:1] are ignored and bits [7:k+1] must equal the corresponding bits of {own2_addr,1'b0}. Code 0 compares all seven bits. With own2_en=0 there is no match.
- R4: When the mask code is non-zero, a reserved address is never accepted through own address 2. A reserved address has byte bits [7:4] equal to 0000 or 1111. With code 7 every other seven-bit address is accepted.
- R5: A first byte of 0x00 is acknowledged when gc_en=1 and refused when gc_en=0.
- R6: Addresses 0001000x are acknowledged only when host_en=1. Addresses 1100001x are acknowledged only when dflt_en=1.
- R7: Addresses 0001100x are acknowledged only when alert_en=1 and host_en=0 (device mode).
- R8: With own1_en=1 and own1_ten=1, a first byte equal to 11110, then own1_addr[9:8], then the R/W bit, produces no decision. The decision follows on the cycle after the second strobe and is ACK only if the second byte equals own1_addr[7:0]. A first byte that does not match this header is decided at once.
- R9: An ACK decision sets match_flag, loads match_code with bits [7:1] of the first byte and loads match_dir with its bit 0 (0 = write, the target receives; 1 = read, the target transmits). A NACK decision leaves match_code and match_dir unchanged.
- R10: match_clr=1 clears match_flag on the next edge, and it wins over an ACK decided on the same edge.
- R11: dec_vld is raised only on the cycle after first_vld, or after second_vld while a ten-bit header is pending. A second_vld with no pending header is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_byte | input | 8 | Received address byte |
| first_vld | input | 1 | addr_byte holds the first address byte |
| second_vld | input | 1 | addr_byte holds the second (ten-bit) address byte |
| own1_addr | input | 10 | Own address 1 |
| own1_ten | input | 1 | Own address 1 is a ten-bit address |
| own1_en | input | 1 | Own address 1 enable |
| own2_addr | input | 7 | Own address 2 |
| own2_msk | input | 3 | Own address 2 mask code |
| own2_en | input | 1 | Own address 2 enable |
| gc_en | input | 1 | General call enable |
| host_en | input | 1 | SMBus host address enable |
| dflt_en | input | 1 | SMBus device-default address enable |
| alert_en | input | 1 | Alert-response address enable |
| match_clr | input | 1 | Write-one-to-clear for match_flag |
| dec_vld | output | 1 | One-cycle decision pulse |
| dec_ack | output | 1 | Verdict: 1 = ACK, 0 = NACK |
| match_flag | output | 1 | Sticky address-matched flag |
| match_code | output | 7 | Captured seven-bit address code |
| match_dir | output | 1 | Captured direction bit |

## Verification
Some rules are checked by the assertions on every cycle. A decision pulse must always follow a strobe. A pending ten-bit header must produce no pulse. A clear must always beat a new match. An ACK must leave the flag set, and a NACK must leave the captured code and direction untouched. The address comparisons can only be shown by the bench's scenarios. These cover the mask widths, the reserved-address exclusion, each special-address enable (including alert in host mode) and the completion of the ten-bit second byte, each with its expected verdict.

// File: rtl/tam_pkg.sv
package tam_pkg;

    localparam int unsigned A7_W  = 7;
    localparam int unsigned BYTE_W = A7_W + 1;
    localparam int unsigned RSV_W = 4;

    localparam logic [A7_W-1:0]  ADR_HOST   = 7'b0001000;
    localparam logic [A7_W-1:0]  ADR_DFLT   = 7'b1100001;
    localparam logic [A7_W-1:0]  ADR_ALERT  = 7'b0001100;
    localparam logic [4:0]       HDR10_TAG  = 5'b11110;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_HDR10 = 1'b1
    } tam_st_e;

    typedef struct packed {
        tam_st_e         st;
        logic            dec_vld;
        logic            dec_ack;
        logic            hit;
        logic [A7_W-1:0] code;
        logic            dir;
        logic [A7_W-1:0] hdr_code;
        logic            hdr_dir;
    } tam_state_t;

endpackage

// File: rtl/tam_own1_cmp.sv
module tam_own1_cmp #(
    parameter int unsigned EXT_W = 10
) (
    input  logic [7:0]       byte_i,
    input  logic [EXT_W-1:0] own_i,
    input  logic             ten_i,
    input  logic             en_i,
    output logic             hit7_o,
    output logic             hdr_o,
    output logic             lo_o
);
    import tam_pkg::*;

    localparam int unsigned HI_W = EXT_W - 8;

    // seven-bit mode: exact compare of address bits
    assign hit7_o = en_i && !ten_i && (byte_i[7:1] == own_i[A7_W-1:0]);
    // ten-bit header: tag, upper address bits, any R/W
    assign hdr_o  = en_i && ten_i && (byte_i[7:3] == HDR10_TAG)
                    && (byte_i[2:1] == own_i[EXT_W-1 -: HI_W]);
    // ten-bit second byte: low eight address bits
    assign lo_o   = en_i && ten_i && (byte_i == own_i[7:0]);

endmodule

// File: rtl/tam_own2_cmp.sv
module tam_own2_cmp #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned MSK_W  = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] own_i,
    input  logic [MSK_W-1:0]  msk_i,
    input  logic              en_i,
    output logic              hit_o
);
    import tam_pkg::*;

    logic [ADDR_W-1:0] care;
    logic              eq;
    logic              rsv;

    // bit i of the seven-bit address is compared when i >= mask code
    for (genvar i = 0; i < ADDR_W; i++) begin : g_care
        assign care[i] = (int'(msk_i) <= i);
    end

    assign eq    = ((care & (addr_i ^ own_i)) == '0);
    assign rsv   = (addr_i[ADDR_W-1 -: RSV_W] == '0) ||
                   (addr_i[ADDR_W-1 -: RSV_W] == '1);
    assign hit_o = en_i && eq && !((msk_i != '0) && rsv);

endmodule

// File: rtl/tam_special_dec.sv
module tam_special_dec (
    input  logic [7:0] byte_i,
    input  logic       gc_en_i,
    input  logic       host_en_i,
    input  logic       dflt_en_i,
    input  logic       alert_en_i,
    output logic       hit_o
);
    import tam_pkg::*;

    logic gc_hit, host_hit, dflt_hit, alert_hit;

    assign gc_hit    = gc_en_i && (byte_i == 8'h00);
    assign host_hit  = host_en_i && (byte_i[7:1] == ADR_HOST);
    assign dflt_hit  = dflt_en_i && (byte_i[7:1] == ADR_DFLT);
    // alert response only answered in device mode
    assign alert_hit = alert_en_i && !host_en_i && (byte_i[7:1] == ADR_ALERT);
    assign hit_o     = gc_hit || host_hit || dflt_hit || alert_hit;

endmodule

// File: rtl/tam_addr_filter.sv
module tam_addr_filter #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned EXT_W  = 10,
    parameter int unsigned MSK_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr_byte,
    input  logic              first_vld,
    input  logic              second_vld,
    input  logic [EXT_W-1:0]  own1_addr,
    input  logic              own1_ten,
    input  logic              own1_en,
    input  logic [ADDR_W-1:0] own2_addr,
    input  logic [MSK_W-1:0]  own2_msk,
    input  logic              own2_en,
    input  logic              gc_en,
    input  logic              host_en,
    input  logic              dflt_en,
    input  logic              alert_en,
    input  logic              match_clr,
    output logic              dec_vld,
    output logic              dec_ack,
    output logic              match_flag,
    output logic [ADDR_W-1:0] match_code,
    output logic              match_dir
);
    import tam_pkg::*;

    tam_state_t st_d, st_q;
    logic o1_hit7, o1_hdr, o1_lo, o2_hit, sp_hit;

    tam_own1_cmp #(.EXT_W(EXT_W)) own1_i (
        .byte_i (addr_byte),
        .own_i  (own1_addr),
        .ten_i  (own1_ten),
        .en_i   (own1_en),
        .hit7_o (o1_hit7),
        .hdr_o  (o1_hdr),
        .lo_o   (o1_lo)
    );

    tam_own2_cmp #(.ADDR_W(ADDR_W), .MSK_W(MSK_W)) own2_i (
        .addr_i (addr_byte[7:1]),
        .own_i  (own2_addr),
        .msk_i  (own2_msk),
        .en_i   (own2_en),
        .hit_o  (o2_hit)
    );

    tam_special_dec spec_i (
        .byte_i     (addr_byte),
        .gc_en_i    (gc_en),
        .host_en_i  (host_en),
        .dflt_en_i  (dflt_en),
        .alert_en_i (alert_en),
        .hit_o      (sp_hit)
    );

    always_comb begin
        st_d         = st_q;
        st_d.dec_vld = 1'b0;
        st_d.dec_ack = 1'b0;
        if (first_vld) begin
            if (o1_hdr) begin
                st_d.st       = ST_HDR10;
                st_d.hdr_code = addr_byte[7:1];
                st_d.hdr_dir  = addr_byte[0];
            end else begin
                st_d.st      = ST_IDLE;
                st_d.dec_vld = 1'b1;
                st_d.dec_ack = o1_hit7 || o2_hit || sp_hit;
                if (st_d.dec_ack) begin
                    st_d.hit  = 1'b1;
                    st_d.code = addr_byte[7:1];
                    st_d.dir  = addr_byte[0];
                end
            end
        end else if (second_vld && (st_q.st == ST_HDR10)) begin
            st_d.st      = ST_IDLE;
            st_d.dec_vld = 1'b1;
            st_d.dec_ack = o1_lo;
            if (o1_lo) begin
                st_d.hit  = 1'b1;
                st_d.code = st_q.hdr_code;
                st_d.dir  = st_q.hdr_dir;
            end
        end
        if (match_clr) begin
            st_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_vld    = st_q.dec_vld;
    assign dec_ack    = st_q.dec_ack;
    assign match_flag = st_q.hit;
    assign match_code = st_q.code;
    assign match_dir  = st_q.dir;

    AST_DEC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> $past(first_vld || second_vld)); // R11

    AST_HDR10_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (first_vld && own1_en && own1_ten && (addr_byte[7:3] == 5'b11110)
         && (addr_byte[2:1] == own1_addr[EXT_W-1 -: 2])) |=> !dec_vld); // R8

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        match_clr |=> !match_flag); // R10

    AST_ACK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_ack && !$past(match_clr)) |-> match_flag); // R9

    AST_NACK_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !dec_ack) |-> ($stable(match_code) && $stable(match_dir))); // R9

endmodule

// File: tb/tam_addr_filter_tb_top.sv
module tam_addr_filter_tb_top;

    typedef struct packed {
        logic [9:0] o1;
        logic       ten;
        logic       e1;
        logic [6:0] o2;
        logic [2:0] msk;
        logic       e2;
        logic       gc;
        logic       hst;
        logic       dft;
        logic       alr;
        logic [7:0] b1;
        logic       two;
        logic [7:0] b2;
        logic       ack;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        // R2 own1 seven-bit hit, disabled, miss
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hA4,1'b0,8'h00,1'b1},
        '{10'h052,1'b0,1'b0,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hA4,1'b0,8'h00,1'b0},
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hA7,1'b0,8'h00,1'b0},
        // R3 own2 exact, miss, masked hit, masked miss, disabled
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h61,1'b0,8'h00,1'b1},
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h62,1'b0,8'h00,1'b0},
        '{10'h052,1'b0,1'b1,7'h30,3'd2,1'b1,1'b0,1'b0,1'b0,1'b0,8'h66,1'b0,8'h00,1'b1},
        '{10'h052,1'b0,1'b1,7'h30,3'd2,1'b1,1'b0,1'b0,1'b0,1'b0,8'h68,1'b0,8'h00,1'b0},
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h60,1'b0,8'h00,1'b0},
        // R4 mask 7: ordinary hit, reserved 1111xxx, reserved 0000xxx
        '{10'h052,1'b0,1'b1,7'h30,3'd7,1'b1,1'b0,1'b0,1'b0,1'b0,8'h8A,1'b0,8'h00,1'b1},
        '{10'h052,1'b0,1'b1,7'h30,3'd7,1'b1,1'b0,1'b0,1'b0,1'b0,8'hF6,1'b0,8'h00,1'b0},
        '{10'h052,1'b0,1'b1,7'h30,3'd7,1'b1,1'b0,1'b0,1'b0,1'b0,8'h0A,1'b0,8'h00,1'b0},
        // R5 general call on / off
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b1},
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0},
        // R6 host on / off, device default on / off
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h10,1'b0,8'h00,1'b1},
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h10,1'b0,8'h00,1'b0},
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,8'hC3,1'b0,8'h00,1'b1},
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hC3,1'b0,8'h00,1'b0},
        // R7 alert in device mode, in host mode, disabled
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h19,1'b0,8'h00,1'b1},
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b1,1'b0,1'b1,8'h19,1'b0,8'h00,1'b0},
        '{10'h052,1'b0,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h19,1'b0,8'h00,1'b0},
        // R8 ten-bit: write hit, low miss, header miss, seven-bit form, read hit
        '{10'h2A5,1'b1,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hF4,1'b1,8'hA5,1'b1},
        '{10'h2A5,1'b1,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hF4,1'b1,8'hA4,1'b0},
        '{10'h2A5,1'b1,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hF2,1'b0,8'h00,1'b0},
        '{10'h2A5,1'b1,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h4A,1'b0,8'h00,1'b0},
        '{10'h2A5,1'b1,1'b1,7'h30,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hF5,1'b1,8'hA5,1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_byte = '0;
    logic       first_vld = 1'b0, second_vld = 1'b0;
    logic [9:0] own1_addr = '0;
    logic       own1_ten = 1'b0, own1_en = 1'b0;
    logic [6:0] own2_addr = '0;
    logic [2:0] own2_msk = '0;
    logic       own2_en = 1'b0, gc_en = 1'b0, host_en = 1'b0;
    logic       dflt_en = 1'b0, alert_en = 1'b0, match_clr = 1'b0;
    logic       dec_vld, dec_ack, match_flag, match_dir;
    logic [6:0] match_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [6:0] exp_code = '0;
    logic       exp_dir = 1'b0;

    always #5 clk = ~clk;

    tam_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .addr_byte(addr_byte),
        .first_vld(first_vld), .second_vld(second_vld),
        .own1_addr(own1_addr), .own1_ten(own1_ten), .own1_en(own1_en),
        .own2_addr(own2_addr), .own2_msk(own2_msk), .own2_en(own2_en),
        .gc_en(gc_en), .host_en(host_en), .dflt_en(dflt_en), .alert_en(alert_en),
        .match_clr(match_clr), .dec_vld(dec_vld), .dec_ack(dec_ack),
        .match_flag(match_flag), .match_code(match_code), .match_dir(match_dir)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 dec_vld", 32'(dec_vld), 0);
        chk("R1 dec_ack", 32'(dec_ack), 0);
        chk("R1 match_flag", 32'(match_flag), 0);
        chk("R1 match_code", 32'(match_code), 0);
        chk("R1 match_dir", 32'(match_dir), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            own1_addr = VECS[v].o1; own1_ten = VECS[v].ten; own1_en = VECS[v].e1;
            own2_addr = VECS[v].o2; own2_msk = VECS[v].msk; own2_en = VECS[v].e2;
            gc_en = VECS[v].gc; host_en = VECS[v].hst;
            dflt_en = VECS[v].dft; alert_en = VECS[v].alr;
            addr_byte = VECS[v].b1;
            first_vld = 1'b1;
            @(negedge clk);
            first_vld = 1'b0;
            if (VECS[v].two) begin
                // R8 no decision on a matching ten-bit header
                chk("R8 header defers", 32'(dec_vld), 0);
                addr_byte = VECS[v].b2;
                second_vld = 1'b1;
                @(negedge clk);
                second_vld = 1'b0;
            end
            chk($sformatf("R2..R8 row %0d dec_vld", v), 32'(dec_vld), 1);
            chk($sformatf("R2..R8 row %0d dec_ack", v), 32'(dec_ack), 32'(VECS[v].ack));
            if (VECS[v].ack) begin
                exp_code = VECS[v].b1[7:1];
                exp_dir  = VECS[v].b1[0];
                chk("R9 flag set", 32'(match_flag), 1);
            end
            chk("R9 code", 32'(match_code), 32'(exp_code));
            chk("R9 dir", 32'(match_dir), 32'(exp_dir));
            // R10 clear the flag after every row
            match_clr = 1'b1;
            @(negedge clk);
            match_clr = 1'b0;
            chk("R10 cleared", 32'(match_flag), 0);
            chk("R11 pulse single", 32'(dec_vld), 0);
        end

        // R10 clear wins over a simultaneous acknowledge
        own1_addr = 10'h052; own1_ten = 1'b0; own1_en = 1'b1;
        addr_byte = 8'hA5;
        first_vld = 1'b1;
        match_clr = 1'b1;
        @(negedge clk);
        first_vld = 1'b0;
        match_clr = 1'b0;
        chk("R10 same-cycle ack", 32'(dec_ack), 1);
        chk("R10 same-cycle flag", 32'(match_flag), 0);
        chk("R9 read dir", 32'(match_dir), 1);

        // R11 second strobe with no pending header is ignored
        own1_addr = 10'h2A5; own1_ten = 1'b1;
        addr_byte = 8'hA5;
        second_vld = 1'b1;
        @(negedge clk);
        second_vld = 1'b0;
        chk("R11 stray second", 32'(dec_vld), 0);
        chk("R11 stray flag", 32'(match_flag), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule